// File: doc/BRIEF.md
# Pulse-Counted Sequential Bit Shifter

This block shifts an 8-bit word left or right by 0 to 7 places without a barrel network. When a request is accepted, the word goes into a bidirectional shift register. The 3-bit amount goes into one of two down-counting step generators: the left one or the right one, chosen by the direction bit. The loaded generator then sends one single-place shift strobe per clock until its count is used up. After the last strobe, the shifted word is offered on the result stream.

The request side and the result side are both valid/ready streams. A request is taken only in a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so the block holds off new requests from the moment one is accepted until its result has been taken. A result stays offered, unchanged, until the consumer raises `out_ready`. The consumer can hold `out_ready` low as long as it likes. `busy` is a plain status pin that is high while strobes remain to be issued.

Top module: `seq_shifter`

## Requirements
- R1: After reset `in_ready` is 1, and `busy`, `out_valid` and `out_data` are 0.
- R2: With `in_dir` = 0 (left: bits move from LSB toward MSB), the result is the input word shifted up by `in_amt`. Vacated low bits are 0 and bits leaving the MSB end are lost.
- R3: With `in_dir` = 1 (right: bits move from MSB toward LSB), the result is the input word shifted down by `in_amt`. Vacated high bits are 0 and bits leaving the LSB end are lost.
- R4: Take the clock edge that accepts a request with amount N. `out_valid` is first high in the cycle following the N-th edge after that one. For N = 0 this is the cycle right after acceptance, and the result equals the input word.
- R5: `busy` is high for exactly N consecutive cycles after acceptance, is low at all other times, and `in_ready` is low whenever `busy` is high.
- R6: `in_ready` stays low from acceptance until the result is taken. `in_valid` and request data presented while `in_ready` is low change neither the pending result nor the results that follow.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value. `out_data` is 0 whenever `out_valid` is low.
- R8: A result is taken on the edge where `out_valid` and `out_ready` are both high. The block is then idle again, with `in_ready` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle and able to take a request |
| in_data | input | 8 | Word to shift |
| in_amt | input | 3 | Number of places, 0 to 7 |
| in_dir | input | 1 | 0 shifts left, 1 shifts right |
| busy | output | 1 | Shift strobes still pending |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Shifted word, 0 when no result is offered |

## Verification
The hardest case to reach from the ports is a request that arrives while the block cannot take it: during the strobe sequence, or while a finished result is being held back. Reaching it also needs the result stall to overlap with the last strobe. The driver therefore presents junk requests on every busy cycle, and the consumer holds `out_ready` low at random. Words that never entered the scoreboard would then show up as mismatches. Every word, every amount and both directions are swept, and each request's latency and busy length are counted against its amount.

// File: rtl/seqsh_pkg.sv
package seqsh_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shdir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } shst_e;
endpackage

// File: rtl/seqsh_step_gen.sv
module seqsh_step_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] amt,
  output logic             strobe,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)      remain <= '0;
    else if (load)   remain <= amt;
    else if (strobe) remain <= remain - CNT_W'(1);
  end

  assign strobe = (remain != '0);
  assign last   = (remain == CNT_W'(1));

  // R4: after the final strobe no further strobe follows unless reloaded
  p_last_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !strobe);
endmodule

// File: rtl/seqsh_shift_reg.sv
module seqsh_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         step_l,
  input  logic         step_r,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= din;
    else if (step_l) q <= {q[W-2:0], 1'b0};
    else if (step_r) q <= {1'b0, q[W-1:1]};
  end

  // R2/R3: strobes never collide with a load or with each other
  p_no_strobe_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(step_l || step_r));
  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_l, step_r}));
endmodule

// File: rtl/seqsh_ctrl.sv
module seqsh_ctrl
  import seqsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic amt_zero,
  input  logic last_step,
  input  logic out_ready,
  output logic take,
  output logic in_ready,
  output logic busy,
  output logic out_valid
);
  shst_e state, state_nx;

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state == ST_SHIFT);
  assign out_valid = (state == ST_HOLD);
  assign take      = in_valid && in_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (take) state_nx = amt_zero ? ST_HOLD : ST_SHIFT;
      ST_SHIFT: if (last_step) state_nx = ST_HOLD;
      ST_HOLD:  if (out_ready) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  p_zero_amt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && amt_zero) |=> out_valid);
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_idle_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter
  import seqsh_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic              in_dir,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int N_DIR = 2;

  logic             take;
  logic [N_DIR-1:0] strobe, last;
  logic [DATA_W-1:0] word;

  seqsh_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .amt_zero  (in_amt == '0),
    .last_step (|last),
    .out_ready (out_ready),
    .take      (take),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid)
  );

  for (genvar g = 0; g < N_DIR; g++) begin : g_gen
    seqsh_step_gen #(.CNT_W(AMT_W)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take && (in_dir == 1'(g))),
      .amt    (in_amt),
      .strobe (strobe[g]),
      .last   (last[g])
    );
  end

  seqsh_shift_reg #(.W(DATA_W)) u_sreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take),
    .din    (in_data),
    .step_l (strobe[DIR_LEFT]),
    .step_r (strobe[DIR_RIGHT]),
    .q      (word)
  );

  assign out_data = out_valid ? word : '0;

  p_strobe_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> busy);
  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  p_zero_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
endmodule

// File: tb/test_seq_shifter.sv
module test_seq_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_amt = '0;
  logic       in_dir = 1'b0;
  logic       busy;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  seq_shifter i_seq_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amt(in_amt), .in_dir(in_dir), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  // Monitor: random back-pressure, scoreboard compare, hold checks (R7, R8)
  logic [7:0] last_data;
  bit         last_stall = 1'b0;
  always @(negedge clk) begin
    if (running) begin
      out_ready = ($urandom % 3) != 0;
      if (out_valid) begin
        if (last_stall) check("R7 hold", {24'd0, out_data}, {24'd0, last_data});
        if (out_ready) begin
          if (exp_q.size() == 0) check("R6 unexpected result", 1, 0);
          else check("R2/R3 result", {24'd0, out_data}, {24'd0, exp_q.pop_front()});
        end
        last_stall = !out_ready;
        last_data  = out_data;
      end else begin
        last_stall = 1'b0;
        if (out_data !== 8'h00) check("R7 zero", {24'd0, out_data}, 0);
      end
    end
  end

  task automatic do_op(input logic [7:0] d, input logic [2:0] a, input logic dir);
    int lat;
    int nbusy;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_amt = a; in_dir = dir;
    exp_q.push_back(dir ? (d >> a) : 8'(d << a));
    lat = 0; nbusy = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (busy) begin
        nbusy++;
        if (in_ready) check("R5 ready while busy", 1, 0);
        // junk request while not ready (R6)
        in_valid = 1'b1; in_data = ~d ^ 8'h5A; in_amt = ~a; in_dir = ~dir;
      end else begin
        in_valid = 1'b0;
      end
      if (out_valid) break;
      if (lat > 12) break;
    end
    in_valid = 1'b0;
    check("R4 latency", lat, a + 1);
    check("R5 busy length", nbusy, a);
    // after result taken: idle next cycle (R8)
    while (out_valid) @(negedge clk);
    check("R8 idle after take", {31'd0, in_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in_ready", {31'd0, in_ready}, 1);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 out_data", {24'd0, out_data}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R2 corner: left by 7 keeps only bit 0 moved to MSB
    do_op(8'hFF, 3'd7, 1'b0);
    // R3 corner: right by 7 keeps only MSB moved to LSB
    do_op(8'hFF, 3'd7, 1'b1);
    // R4 zero amount passes word through
    do_op(8'hA5, 3'd0, 1'b1);
    for (int w = 0; w < 256; w++)
      for (int a = 0; a < 8; a++)
        for (int dr = 0; dr < 2; dr++)
          do_op(8'(w), 3'(a), 1'(dr));
    repeat (4) @(negedge clk);
    check("R6 all results drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule